// File: doc/BRIEF.md
# x86 Prefix and Opcode-Map Decoder

This block takes a 32-bit-mode x86 instruction stream one byte per cycle over a valid/ready handshake. It consumes the run of legacy prefix bytes and any REX byte in front of an instruction. It then follows the 0F escape and the 0F 38 escape to the final opcode byte. In the cycle after that byte is accepted, it presents one decode record.

The record carries these fields:
- the opcode map and the opcode byte;
- a 2-bit SIMD variant selector, which merges all 66/F2/F3 bytes seen using a fixed priority and a last-wins rule;
- an operand-size flag and a string-repeat flag;
- a branch-hint field and a segment-override field;
- the effective REX bits;
- a multi-byte NOP flag;
- the total byte count;
- an over-length error flag.

ModR/M and later bytes are left to downstream logic.

All collected prefix state is cleared whenever a record is produced. A new instruction can therefore start on the very next byte.

Top module: `insn_pfx_decode`

## Requirements
- R1: `rec_sel` gives the SIMD variant. Code 0 means no 66/F2/F3 byte was seen (packed-single for 0F 58). Code 1 means only 66 was seen (packed-double). Code 2 means F3 (scalar-single). Code 3 means F2 (scalar-double).
- R2: When both F2 and F3 appear in one prefix run, the later of the two sets `rec_sel`.
- R3: When 66 appears with F2 or F3, in either order, the REP-group byte sets `rec_sel`. `rec_opsize` is 1 whenever a 66 byte was present.
- R4: A repeated prefix acts like a single copy of it. `rec_len` counts every byte of the instruction, including the opcode. `rec_nop` is 1 in two cases:
  - opcode 90 in the one-byte map with no F2/F3 present;
  - opcode 1F in the 0F map.
- R5: A byte 40h–4Fh sets `rec_rex_v`=1, with `rec_rex` equal to its low nibble, only if it is the last byte before the 0F escape or the opcode. A REX byte followed by any legacy prefix is discarded (`rec_rex_v`=0). A later REX byte replaces an earlier one.
- R6: `rec_map` is 0 for the one-byte map, 1 after 0F, and 2 after 0F 38. `rec_opcode` is the byte that follows the escape.
- R7: `rec_rep` is 1 only when F2 or F3 was present and the map is 0. Used as a mandatory prefix in maps 1 and 2, F2/F3 never sets it.
- R8: A conditional jump is opcodes 70–7F in map 0, or 80–8F in map 1. On a conditional jump whose last segment byte is 2E, `rec_hint` is 1 (not taken); if that byte is 3E, `rec_hint` is 2 (taken); in both cases `rec_seg` is 0. In every other case `rec_hint` is 0 and `rec_seg` gives the last segment byte: 26→1, 2E→2, 36→3, 3E→4, 64→5, 65→6, none→0.
- R9: When the 15th byte (MAX_LEN) is accepted without completing an opcode, a record is produced with `rec_err`=1 and `rec_len`=15, and all prefix state is cleared. An opcode that arrives as the 15th byte decodes normally.
- R10: With `out_ready` held high, single-byte instructions sent back to back are accepted every cycle. Each record appears in the cycle after its last byte. A record stays unchanged while `out_ready` is low, and during that time `in_ready` is low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Decode record valid |
| out_ready | input | 1 | Consumer takes the record |
| rec_err | output | 1 | Over-length error |
| rec_len | output | LEN_W | Instruction byte count |
| rec_map | output | 2 | Opcode map code |
| rec_opcode | output | 8 | Final opcode byte |
| rec_sel | output | 2 | SIMD variant selector |
| rec_opsize | output | 1 | 66 byte present |
| rec_rep | output | 1 | String-repeat flag |
| rec_hint | output | 2 | Branch hint code |
| rec_seg | output | 3 | Segment override code |
| rec_rex_v | output | 1 | Effective REX present |
| rec_rex | output | 4 | Effective REX low nibble |
| rec_nop | output | 1 | NOP instruction flag |

## Verification
The properties assume that `in_byte` and `in_valid` stay stable between the handshake edges. They also assume the consumer never retracts `out_ready` in a way that matters, since a record is simply held until it is taken.

The stimulus drives both inputs once per cycle, half a period away from the active edge. It changes the byte only after an acceptance. It toggles `out_ready` from a pseudo-random sequence only in the stall phase.

An exhaustive sweep sends every prefix run of up to three bytes from a seven-byte alphabet, ahead of five opcode tails. This covers the orderings of 66/F2/F3, REX placement and segment hints.

## Settings
The bench also covers the following cases:
- randomised prefix runs over all twelve prefix kinds;
- the 15-byte boundary on both sides.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the prefix and opcode-map decoder.
// Assumes 8-bit stream bytes; codes here are visible at the top ports.
package pd_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MAP_BASE = 2'd0,
        MAP_0F   = 2'd1,
        MAP_0F38 = 2'd2
    } map_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_66   = 2'd1,
        SEL_F3   = 2'd2,
        SEL_F2   = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        HINT_NONE = 2'd0,
        HINT_NT   = 2'd1,
        HINT_T    = 2'd2
    } hint_e;

    typedef enum logic [2:0] {
        BK_OTHER = 3'd0,
        BK_SEG   = 3'd1,
        BK_OPSZ  = 3'd2,
        BK_REPNE = 3'd3,
        BK_REPE  = 3'd4,
        BK_MISC  = 3'd5,
        BK_REX   = 3'd6,
        BK_ESC   = 3'd7
    } kind_e;
endpackage

// File: rtl/pd_classify.sv
`timescale 1ns/1ps
// Module: pd_classify
// Purely combinational sort of one stream byte into a prefix kind and,
// for segment bytes, a 3-bit segment code. Assumes 32-bit mode, with
// 40h-4Fh treated as REX as the decoder contract requires.
module pd_classify
    import pd_pkg::*;
(
    input  logic [BYTE_W-1:0] b,
    output kind_e             kind,
    output logic [2:0]        seg_code
);
    // Byte kind and segment code lookup
    always_comb begin
        kind     = BK_OTHER;
        seg_code = 3'd0;
        case (b)
            8'h26: begin kind = BK_SEG; seg_code = 3'd1; end
            8'h2E: begin kind = BK_SEG; seg_code = 3'd2; end
            8'h36: begin kind = BK_SEG; seg_code = 3'd3; end
            8'h3E: begin kind = BK_SEG; seg_code = 3'd4; end
            8'h64: begin kind = BK_SEG; seg_code = 3'd5; end
            8'h65: begin kind = BK_SEG; seg_code = 3'd6; end
            8'h66: kind = BK_OPSZ;
            8'hF2: kind = BK_REPNE;
            8'hF3: kind = BK_REPE;
            8'hF0, 8'h67: kind = BK_MISC;
            8'h0F: kind = BK_ESC;
            default: if (b[7:4] == 4'h4) kind = BK_REX;
        endcase
    end
endmodule

// File: rtl/pd_collect.sv
`timescale 1ns/1ps
// Module: pd_collect
// Holds the prefix state for the instruction in flight and decides, for
// each accepted byte, whether it completes a record. Record fields are
// formed combinationally from state plus the current byte; the caller
// registers them. Assumes `take` is high only for an accepted byte.
module pd_collect
    import pd_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] b,
    input  kind_e             kind,
    input  logic [2:0]        seg_code,
    output logic              emit,
    output logic              f_err,
    output logic [LEN_W-1:0]  f_len,
    output map_e              f_map,
    output sel_e              f_sel,
    output logic              f_opsize,
    output logic              f_rep,
    output hint_e             f_hint,
    output logic [2:0]        f_seg,
    output logic              f_rex_v,
    output logic [3:0]        f_rex,
    output logic              f_nop
);
    typedef enum logic [1:0] {PH_PFX, PH_ESC, PH_ESC38} phase_e;

    phase_e           phase;
    logic [LEN_W-1:0] cnt;
    logic             saw66;
    sel_e             rep_q;
    logic [2:0]       seg_q;
    logic             rex_v_q;
    logic [3:0]       rex_q;

    logic             is_final;
    logic             len_hit;
    logic             jcc;
    logic [LEN_W-1:0] cnt_nxt;

    // Completion, length limit and field formation for the current byte
    always_comb begin
        cnt_nxt  = cnt + 1'b1;
        len_hit  = (cnt_nxt == LEN_W'(MAX_LEN));
        case (phase)
            PH_PFX:  is_final = (kind == BK_OTHER);
            PH_ESC:  is_final = (b != 8'h38);
            default: is_final = 1'b1;
        endcase
        emit  = take && (is_final || len_hit);
        f_err = !is_final;
        f_len = cnt_nxt;
        case (phase)
            PH_PFX:  f_map = MAP_BASE;
            PH_ESC:  f_map = MAP_0F;
            default: f_map = MAP_0F38;
        endcase
        f_sel    = (rep_q != SEL_NONE) ? rep_q : (saw66 ? SEL_66 : SEL_NONE);
        f_opsize = saw66;
        f_rep    = (f_map == MAP_BASE) && (rep_q != SEL_NONE);
        jcc      = ((f_map == MAP_BASE) && (b[7:4] == 4'h7)) ||
                   ((f_map == MAP_0F)   && (b[7:4] == 4'h8));
        f_hint   = HINT_NONE;
        if (jcc && seg_q == 3'd2) f_hint = HINT_NT;
        if (jcc && seg_q == 3'd4) f_hint = HINT_T;
        f_seg    = (f_hint != HINT_NONE) ? 3'd0 : seg_q;
        f_rex_v  = rex_v_q;
        f_rex    = rex_q;
        f_nop    = ((f_map == MAP_BASE) && (b == 8'h90) && (rep_q == SEL_NONE)) ||
                   ((f_map == MAP_0F) && (b == 8'h1F));
    end

    // Prefix state update; everything clears when a record is emitted
    always_ff @(posedge clk) begin
        if (!rst_n || emit) begin
            phase   <= PH_PFX;
            cnt     <= '0;
            saw66   <= 1'b0;
            rep_q   <= SEL_NONE;
            seg_q   <= 3'd0;
            rex_v_q <= 1'b0;
            rex_q   <= 4'd0;
        end else if (take) begin
            cnt <= cnt_nxt;
            if (phase == PH_PFX) begin
                case (kind)
                    BK_SEG:   begin seg_q <= seg_code; rex_v_q <= 1'b0; end
                    BK_OPSZ:  begin saw66 <= 1'b1;     rex_v_q <= 1'b0; end
                    BK_REPNE: begin rep_q <= SEL_F2;   rex_v_q <= 1'b0; end
                    BK_REPE:  begin rep_q <= SEL_F3;   rex_v_q <= 1'b0; end
                    BK_MISC:  rex_v_q <= 1'b0;
                    BK_REX:   begin rex_v_q <= 1'b1;   rex_q <= b[3:0]; end
                    BK_ESC:   phase <= PH_ESC;
                    default:  ;
                endcase
            end else if (phase == PH_ESC) begin
                phase <= PH_ESC38;
            end
        end
    end
endmodule

// File: rtl/insn_pfx_decode.sv
`timescale 1ns/1ps
// Module: insn_pfx_decode (top)
// Accepts one instruction byte per handshake, delegates classification
// and prefix collection, and holds each decode record in an output
// register until the consumer takes it. Assumes 32-bit mode.
module insn_pfx_decode
    import pd_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              rec_err,
    output logic [LEN_W-1:0]  rec_len,
    output logic [1:0]        rec_map,
    output logic [7:0]        rec_opcode,
    output logic [1:0]        rec_sel,
    output logic              rec_opsize,
    output logic              rec_rep,
    output logic [1:0]        rec_hint,
    output logic [2:0]        rec_seg,
    output logic              rec_rex_v,
    output logic [3:0]        rec_rex,
    output logic              rec_nop
);
    kind_e            kind;
    logic [2:0]       seg_code;
    logic             take;
    logic             emit;
    logic             f_err, f_opsize, f_rep, f_rex_v, f_nop;
    logic [LEN_W-1:0] f_len;
    map_e             f_map;
    sel_e             f_sel;
    hint_e            f_hint;
    logic [2:0]       f_seg;
    logic [3:0]       f_rex;

    // Input acceptance: stall only while an untaken record is held
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    pd_classify i_classify (
        .b        (in_byte),
        .kind     (kind),
        .seg_code (seg_code)
    );

    pd_collect #(.MAX_LEN(MAX_LEN)) i_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .b        (in_byte),
        .kind     (kind),
        .seg_code (seg_code),
        .emit     (emit),
        .f_err    (f_err),
        .f_len    (f_len),
        .f_map    (f_map),
        .f_sel    (f_sel),
        .f_opsize (f_opsize),
        .f_rep    (f_rep),
        .f_hint   (f_hint),
        .f_seg    (f_seg),
        .f_rex_v  (f_rex_v),
        .f_rex    (f_rex),
        .f_nop    (f_nop)
    );

    // Output valid flag: set on emit, cleared when taken
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (emit)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Record register: loads on emit, otherwise holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_err    <= 1'b0;
            rec_len    <= '0;
            rec_map    <= 2'd0;
            rec_opcode <= 8'd0;
            rec_sel    <= 2'd0;
            rec_opsize <= 1'b0;
            rec_rep    <= 1'b0;
            rec_hint   <= 2'd0;
            rec_seg    <= 3'd0;
            rec_rex_v  <= 1'b0;
            rec_rex    <= 4'd0;
            rec_nop    <= 1'b0;
        end else if (emit) begin
            rec_err    <= f_err;
            rec_len    <= f_len;
            rec_map    <= f_map;
            rec_opcode <= in_byte;
            rec_sel    <= f_sel;
            rec_opsize <= f_opsize;
            rec_rep    <= f_rep;
            rec_hint   <= f_hint;
            rec_seg    <= f_seg;
            rec_rex_v  <= f_rex_v;
            rec_rex    <= f_rex;
            rec_nop    <= f_nop;
        end
    end
endmodule

// File: rtl/pd_checker.sv
`timescale 1ns/1ps
// Module: pd_checker
// Temporal properties on the decoder's ports, attached by bind.
// Assumes the consumer's out_ready is a registered, glitch-free level.
module pd_checker #(
    parameter int MAX_LEN = 15,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             rec_err,
    input logic [LEN_W-1:0] rec_len,
    input logic [1:0]       rec_map,
    input logic [7:0]       rec_opcode,
    input logic [1:0]       rec_sel,
    input logic             rec_rep,
    input logic [1:0]       rec_hint,
    input logic [2:0]       rec_seg,
    input logic             rec_nop
);
    // R10
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(rec_len) &&
        $stable(rec_opcode) && $stable(rec_sel) && $stable(rec_map));

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R9
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> rec_len != 0 && rec_len <= LEN_W'(MAX_LEN));

    // R9
    err_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && rec_err |-> rec_len == LEN_W'(MAX_LEN));

    // R7
    rep_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !rec_err && rec_rep |-> rec_map == 2'd0);

    // R8
    hint_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !rec_err && rec_hint != 2'd0 |-> rec_seg == 3'd0);

    // R6
    map_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !rec_err && rec_map == 2'd2 |-> rec_len >= LEN_W'(3));

    // R4
    nop_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !rec_err && rec_nop && rec_map == 2'd0 |-> rec_sel <= 2'd1);
endmodule

bind insn_pfx_decode pd_checker #(.MAX_LEN(MAX_LEN)) i_pd_checker (.*);

// File: tb/test_insn_pfx_decode.sv
`timescale 1ns/1ps
// Bench: exhaustive short prefix runs, directed cases and random runs,
// each checked against a byte-list reference model of the requirements.
module test_insn_pfx_decode;
    localparam int MAX_LEN = 15;
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_byte = 8'h00;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic             rec_err, rec_opsize, rec_rep, rec_rex_v, rec_nop;
    logic [LEN_W-1:0] rec_len;
    logic [1:0]       rec_map, rec_sel, rec_hint;
    logic [7:0]       rec_opcode;
    logic [2:0]       rec_seg;
    logic [3:0]       rec_rex;

    always #2.5 clk = ~clk;

    insn_pfx_decode #(.MAX_LEN(MAX_LEN)) i_insn_pfx_decode (.*);

    typedef struct {
        bit       err;
        int       len;
        int       map;
        bit [7:0] op;
        int       sel;
        bit       opsz;
        bit       rep;
        int       hint;
        int       seg;
        bit       rexv;
        bit [3:0] rex;
        bit       nop;
    } exp_t;

    exp_t     exp_q[$];
    bit [7:0] cur[$];
    int       n_tests = 0;
    int       n_fail = 0;
    int       stalls = 0;
    bit       stall_mode = 0;
    bit       done = 0;
    bit [31:0] lfsr = 32'h1234_5678;

    function automatic bit [31:0] lfsr_next(bit [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    function automatic bit is_legacy(bit [7:0] b);
        return b inside {8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                         8'h26, 8'h64, 8'h65, 8'h66, 8'h67};
    endfunction

    function automatic int seg_of(bit [7:0] b);
        case (b)
            8'h26: return 1;  8'h2E: return 2;  8'h36: return 3;
            8'h3E: return 4;  8'h64: return 5;  8'h65: return 6;
            default: return 0;
        endcase
    endfunction

    // Reference model: judge completion from the byte list, then derive fields
    task automatic model_byte(bit [7:0] b);
        exp_t e;
        int idx, map;
        bit complete;
        bit [7:0] op;
        int last_rep, lseg;
        bit any66, jcc;
        cur.push_back(b);
        idx = 0;
        while (idx < cur.size() && (is_legacy(cur[idx]) || cur[idx][7:4] == 4'h4)) idx++;
        complete = 0; map = 0; op = 0;
        if (idx < cur.size()) begin
            if (cur[idx] != 8'h0F) begin complete = 1; map = 0; op = cur[idx]; end
            else if (idx + 1 < cur.size()) begin
                if (cur[idx+1] != 8'h38) begin complete = 1; map = 1; op = cur[idx+1]; end
                else if (idx + 2 < cur.size()) begin complete = 1; map = 2; op = cur[idx+2]; end
            end
        end
        if (!complete && cur.size() != MAX_LEN) return;
        e = '{default: 0};
        e.len = cur.size();
        if (!complete) begin
            e.err = 1;
        end else begin
            last_rep = 0; any66 = 0; lseg = 0;
            for (int i = 0; i < idx; i++) begin
                if (cur[i] == 8'hF2) last_rep = 3;
                if (cur[i] == 8'hF3) last_rep = 2;
                if (cur[i] == 8'h66) any66 = 1;
                if (seg_of(cur[i]) != 0) lseg = seg_of(cur[i]);
            end
            e.map = map; e.op = op; e.opsz = any66;
            e.sel = (last_rep != 0) ? last_rep : (any66 ? 1 : 0);
            e.rep = (map == 0) && (last_rep != 0);
            jcc = (map == 0 && op[7:4] == 4'h7) || (map == 1 && op[7:4] == 4'h8);
            e.seg = lseg;
            if (jcc && lseg == 2) begin e.hint = 1; e.seg = 0; end
            if (jcc && lseg == 4) begin e.hint = 2; e.seg = 0; end
            if (idx > 0 && cur[idx-1][7:4] == 4'h4) begin e.rexv = 1; e.rex = cur[idx-1][3:0]; end
            e.nop = (map == 0 && op == 8'h90 && last_rep == 0) || (map == 1 && op == 8'h1F);
        end
        exp_q.push_back(e);
        cur.delete();
    endtask

    // Compare one taken record; the first mismatching field names the requirement
    task automatic check_rec(exp_t e);
        string tag;
        tag = "";
        n_tests++;
        if (rec_err !== e.err) tag = "R9";
        else if (int'(rec_len) != e.len) tag = e.err ? "R9" : "R4";
        else if (!e.err) begin
            if (int'(rec_map) != e.map || rec_opcode !== e.op) tag = "R6";
            else if (int'(rec_sel) != e.sel) tag = "R2";
            else if (rec_opsize !== e.opsz) tag = "R3";
            else if (rec_rep !== e.rep) tag = "R7";
            else if (int'(rec_hint) != e.hint || int'(rec_seg) != e.seg) tag = "R8";
            else if (rec_rex_v !== e.rexv || (e.rexv && rec_rex !== e.rex)) tag = "R5";
            else if (rec_nop !== e.nop) tag = "R4";
        end
        if (tag != "") begin
            n_fail++;
            $display("FAIL %s: actual err=%0d len=%0d map=%0d op=%h sel=%0d osz=%0d rep=%0d hint=%0d seg=%0d rexv=%0d rex=%h nop=%0d expected err=%0d len=%0d map=%0d op=%h sel=%0d osz=%0d rep=%0d hint=%0d seg=%0d rexv=%0d rex=%h nop=%0d",
                tag, rec_err, rec_len, rec_map, rec_opcode, rec_sel, rec_opsize, rec_rep,
                rec_hint, rec_seg, rec_rex_v, rec_rex, rec_nop,
                e.err, e.len, e.map, e.op, e.sel, e.opsz, e.rep, e.hint, e.seg,
                e.rexv, e.rex, e.nop);
        end
    endtask

    // Monitor: drive out_ready at the falling edge, check records that will be taken
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            lfsr = lfsr_next(lfsr);
            out_ready = stall_mode ? lfsr[3] : 1'b1;
            #1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R10: actual unexpected record expected none");
                end else check_rec(exp_q.pop_front());
            end
        end
    end

    task automatic send_byte(bit [7:0] b);
        bit acc;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = b;
            #2;
            acc = in_ready;
            if (!acc) stalls++;
            @(posedge clk);
        end
        model_byte(b);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_tail(int t);
        case (t)
            0: begin send_byte(8'h0F); send_byte(8'h58); end
            1: begin send_byte(8'h0F); send_byte(8'h38); send_byte(8'h01); end
            2: send_byte(8'h74);
            3: send_byte(8'h90);
            default: begin send_byte(8'h0F); send_byte(8'h84); end
        endcase
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    bit [7:0] sweep_set[7] = '{8'h66, 8'hF2, 8'hF3, 8'h2E, 8'h3E, 8'h45, 8'h64};
    bit [7:0] all_pfx[12] = '{8'hF0, 8'hF2, 8'hF3, 8'h2E, 8'h36, 8'h3E,
                             8'h26, 8'h64, 8'h65, 8'h66, 8'h67, 8'h4B};

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11: reset state
        n_tests++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: actual valid=%0d ready=%0d expected valid=0 ready=1", out_valid, in_ready);
        end
        // R1: the four variants of 0F 58
        send_tail(0);
        send_byte(8'h66); send_tail(0);
        send_byte(8'hF2); send_tail(0);
        send_byte(8'hF3); send_tail(0);
        // R3: 66 with a REP byte in either order
        send_byte(8'h66); send_byte(8'hF2); send_tail(0);
        send_byte(8'hF2); send_byte(8'h66); send_tail(0);
        // R2: conflicting REP bytes, last wins
        send_byte(8'hF2); send_byte(8'hF3); send_tail(0);
        send_byte(8'hF3); send_byte(8'hF2); send_tail(0);
        // R4: repeated 66 as padded NOP of length 4
        send_byte(8'h66); send_byte(8'h66); send_byte(8'h66); send_byte(8'h90);
        // R5: REX kept when last, dropped when followed by a prefix
        send_byte(8'h45); send_tail(0);
        send_byte(8'h45); send_byte(8'h66); send_tail(0);
        send_byte(8'h41); send_byte(8'h4C); send_byte(8'h90);
        // R6: three-byte map
        send_byte(8'h66); send_tail(1);
        // R7: mandatory F3 vs string repeat
        send_byte(8'hF3); send_byte(8'h0F); send_byte(8'hE6);
        send_byte(8'hF3); send_byte(8'hA4);
        // R8: hints on conditional jumps, segments elsewhere
        send_byte(8'h2E); send_byte(8'h74);
        send_byte(8'h3E); send_tail(4);
        send_byte(8'h2E); send_byte(8'h90);
        send_byte(8'h64); send_byte(8'h74);
        // R9: opcode as 15th byte, then 15 prefixes with no opcode
        for (int i = 0; i < MAX_LEN - 1; i++) send_byte(8'h66);
        send_byte(8'h90);
        for (int i = 0; i < MAX_LEN; i++) send_byte(8'h3E);
        send_byte(8'h90);
        go_idle();
        drain();
        // R10: back-to-back one-byte instructions never stall
        stalls = 0;
        for (int i = 0; i < 8; i++) send_byte(8'h90);
        go_idle();
        drain();
        n_tests++;
        if (stalls != 0) begin
            n_fail++;
            $display("FAIL R10: actual stalls=%0d expected 0", stalls);
        end
        // R1 R2 R3 R5 R8: every run of up to 3 prefixes from the sweep set
        for (int n = 0; n <= 3; n++) begin
            int combos;
            combos = 1;
            for (int k = 0; k < n; k++) combos *= 7;
            for (int c = 0; c < combos; c++) begin
                for (int t = 0; t < 5; t++) begin
                    int d;
                    d = c;
                    for (int k = 0; k < n; k++) begin
                        send_byte(sweep_set[d % 7]);
                        d /= 7;
                    end
                    send_tail(t);
                end
            end
        end
        go_idle();
        drain();
        // R10 and others: random prefix runs with consumer stalls
        stall_mode = 1;
        for (int i = 0; i < 300; i++) begin
            int np;
            lfsr = lfsr_next(lfsr);
            np = int'(lfsr[2:0]) % 7;
            for (int k = 0; k < np; k++) begin
                lfsr = lfsr_next(lfsr);
                send_byte(all_pfx[int'(lfsr[7:4]) % 12]);
            end
            lfsr = lfsr_next(lfsr);
            send_tail(int'(lfsr[10:8]) % 5);
        end
        go_idle();
        drain();
        stall_mode = 0;
        // R10: every expected record arrived
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10: actual pending=%0d expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule